// File: doc/BRIEF.md
# Packed Lane Add/Subtract Unit with Per-Lane Compare Flags

This unit runs unsigned addition or subtraction on two packed operands. It works either as halfword lanes (two lanes of two bytes) or as byte lanes. Each add or subtract overwrites a register of per-byte "greater-or-equal" flags, one bit per byte. Each flag is set from its lane's carry-out on an add, or from the absence of a borrow on a subtract, and cleared otherwise. A separate select operation reads the stored flags and assembles a result byte by byte. Each byte comes from the first operand where its flag is set and from the second operand where it is clear.

A caller presents both operands, an operation code and a valid strobe in one cycle. On the next clock edge the unit registers the packed result, raises its result-valid output and, for arithmetic operations, updates the flag register. The flag register drives an output, so surrounding logic can merge it into a status word as a contiguous 4-bit field. Lane results are truncated to the lane width, and no carry crosses a lane boundary. Byte lane 0 sits in bits 7:0.

Top module: `simd_addsub_ge`

## Requirements
- R1: While the active-low reset `rst_n` is low, `res_o`, `res_vld_o` and `ge_o` are all zero.
- R2: Op code 0 (halfword add) gives, one cycle later, the low halfword sum in bits 15:0 and the high halfword sum in bits 31:16, each truncated to 16 bits, with no carry from the low halfword into the high one.
- R3: After a halfword add, `ge_o[1:0]` both equal the carry-out of the low halfword sum and `ge_o[3:2]` both equal the carry-out of the high halfword sum.
- R4: Op code 1 (halfword subtract) gives each halfword difference modulo 2^16. Both flag bits of a halfword lane are set when that lane of operand A is greater than or equal to that lane of operand B, and cleared otherwise.
- R5: Op code 2 (byte add) gives each byte sum truncated to 8 bits, with byte lane i in bits 8i+7:8i, and sets `ge_o[i]` to the carry-out of lane i.
- R6: Op code 3 (byte subtract) gives each byte difference modulo 256 and sets `ge_o[i]` when byte i of A is greater than or equal to byte i of B, clearing it otherwise.
- R7: Op code 4 (select) gives byte i of A when the flag bit `ge_o[i]` held before the operation is 1, and byte i of B when it is 0.
- R8: The flag register changes only on a valid add or subtract. A select, a reserved op code or a cycle without `in_vld` leaves `ge_o` unchanged, and a cycle without `in_vld` also leaves `res_o` unchanged.
- R9: `res_vld_o` is high in exactly the cycle after a cycle with `in_vld` high, and low after a cycle with it low.
- R10: Reserved op codes 5, 6 and 7 with `in_vld` high give a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (0 hadd, 1 hsub, 2 badd, 3 bsub, 4 select) |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| res_o | output | 32 | Registered packed result |
| res_vld_o | output | 1 | Result valid, one cycle after the strobe |
| ge_o | output | 4 | Stored per-byte greater-or-equal flags, bit i for byte lane i |

## Verification
The hardest state to reach from the ports is a flag register with mixed bits left by one operation, followed at once by a select. An add must also clear flags that an earlier operation had set. To get there, the stimulus places all-ones-plus-one and zero-minus-one operands next to equal-operand subtractions. It also interleaves random arithmetic operations with selects and reserved codes, so every select sees the flags of whichever operation came last. Reset is applied again in the middle of the run to confirm that the flags clear.

// File: rtl/simd_ge_pkg.sv
package simd_ge_pkg;

   typedef enum logic [2:0] {
      SIMD_ADD_H = 3'd0,
      SIMD_SUB_H = 3'd1,
      SIMD_ADD_B = 3'd2,
      SIMD_SUB_B = 3'd3,
      SIMD_SEL   = 3'd4
   } simd_op_e;

   function automatic logic op_is_arith(input logic [2:0] op);
      return (op == SIMD_ADD_H) || (op == SIMD_SUB_H) ||
             (op == SIMD_ADD_B) || (op == SIMD_SUB_B);
   endfunction

   function automatic logic op_is_half(input logic [2:0] op);
      return (op == SIMD_ADD_H) || (op == SIMD_SUB_H);
   endfunction

   function automatic logic op_is_sub(input logic [2:0] op);
      return (op == SIMD_SUB_H) || (op == SIMD_SUB_B);
   endfunction

endpackage

// File: rtl/simd_byte_slice.sv
module simd_byte_slice #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] a_i,
   input  logic [LANE_W-1:0] b_i,
   input  logic              inv_b_i,
   input  logic              cin_i,
   output logic [LANE_W-1:0] sum_o,
   output logic              cout_o
);
   localparam int EXT_W = LANE_W + 1;

   logic [LANE_W-1:0] b_eff;
   logic [EXT_W-1:0]  total;

   always_comb begin
      b_eff = inv_b_i ? ~b_i : b_i;
      total = {1'b0, a_i} + {1'b0, b_eff} + {{LANE_W{1'b0}}, cin_i};
   end

   assign sum_o  = total[LANE_W-1:0];
   assign cout_o = total[EXT_W-1];
endmodule

// File: rtl/simd_ge_map.sv
module simd_ge_map #(
   parameter int NUM_BYTES = 4
) (
   input  logic                 half_i,
   input  logic [NUM_BYTES-1:0] cout_i,
   output logic [NUM_BYTES-1:0] ge_o
);
   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_map
      if (i % 2 == 0) begin : g_even
         assign ge_o[i] = half_i ? cout_i[i+1] : cout_i[i];
      end else begin : g_odd
         assign ge_o[i] = cout_i[i];
      end
   end
endmodule

// File: rtl/simd_byte_select.sv
module simd_byte_select #(
   parameter int LANE_W    = 8,
   parameter int NUM_BYTES = 4
) (
   input  logic [NUM_BYTES-1:0]        ge_i,
   input  logic [LANE_W*NUM_BYTES-1:0] a_i,
   input  logic [LANE_W*NUM_BYTES-1:0] b_i,
   output logic [LANE_W*NUM_BYTES-1:0] y_o
);
   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sel
      assign y_o[i*LANE_W +: LANE_W] = ge_i[i] ? a_i[i*LANE_W +: LANE_W]
                                               : b_i[i*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/simd_addsub_ge.sv
module simd_addsub_ge
   import simd_ge_pkg::*;
#(
   parameter int LANE_W    = 8,
   parameter int NUM_BYTES = 4,
   localparam int DATA_W   = LANE_W * NUM_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic [2:0]           op_i,
   input  logic [DATA_W-1:0]    opa_i,
   input  logic [DATA_W-1:0]    opb_i,
   output logic [DATA_W-1:0]    res_o,
   output logic                 res_vld_o,
   output logic [NUM_BYTES-1:0] ge_o
);
   initial begin
      assert (NUM_BYTES >= 2 && NUM_BYTES % 2 == 0)
         else $error("NUM_BYTES must be even and at least 2");
      assert (LANE_W >= 1)
         else $error("LANE_W must be positive");
   end

   logic                 half_w, sub_w, arith_w;
   logic [DATA_W-1:0]    sum_w, sel_w;
   logic [NUM_BYTES-1:0] cout_w, ge_next_w;
   logic [DATA_W-1:0]    res_q, res_d;
   logic [NUM_BYTES-1:0] ge_q;
   logic                 vld_q;

   assign half_w  = op_is_half(op_i);
   assign sub_w   = op_is_sub(op_i);
   assign arith_w = op_is_arith(op_i);

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
      logic cin_l;
      if (i % 2 == 1) begin : g_upper
         assign cin_l = half_w ? cout_w[i-1] : sub_w;
      end else begin : g_lower
         assign cin_l = sub_w;
      end
      simd_byte_slice #(.LANE_W(LANE_W)) slice_i (
         .a_i    (opa_i[i*LANE_W +: LANE_W]),
         .b_i    (opb_i[i*LANE_W +: LANE_W]),
         .inv_b_i(sub_w),
         .cin_i  (cin_l),
         .sum_o  (sum_w[i*LANE_W +: LANE_W]),
         .cout_o (cout_w[i])
      );
   end

   simd_ge_map #(.NUM_BYTES(NUM_BYTES)) map_i (
      .half_i(half_w),
      .cout_i(cout_w),
      .ge_o  (ge_next_w)
   );

   simd_byte_select #(.LANE_W(LANE_W), .NUM_BYTES(NUM_BYTES)) sel_i (
      .ge_i(ge_q),
      .a_i (opa_i),
      .b_i (opb_i),
      .y_o (sel_w)
   );

   always_comb begin
      if (arith_w)               res_d = sum_w;
      else if (op_i == SIMD_SEL) res_d = sel_w;
      else                       res_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         vld_q <= 1'b0;
         ge_q  <= '0;
      end else begin
         vld_q <= in_vld;
         if (in_vld) res_q <= res_d;
         if (in_vld && arith_w) ge_q <= ge_next_w;
      end
   end

   assign res_o     = res_q;
   assign res_vld_o = vld_q;
   assign ge_o      = ge_q;
endmodule

// File: rtl/simd_ge_chk.sv
module simd_ge_chk #(
   parameter int LANE_W    = 8,
   parameter int NUM_BYTES = 4,
   localparam int DATA_W   = LANE_W * NUM_BYTES
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_vld,
   input logic [2:0]           op_i,
   input logic [DATA_W-1:0]    opa_i,
   input logic [DATA_W-1:0]    opb_i,
   input logic [DATA_W-1:0]    res_o,
   input logic                 res_vld_o,
   input logic [NUM_BYTES-1:0] ge_o
);
   // R9
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> res_vld_o);

   // R9
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !res_vld_o);

   // R8
   ge_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(ge_o));

   // R8
   ge_hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && op_i >= 3'd4) |=> $stable(ge_o));

   // R8
   res_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(res_o));

   // R10
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && op_i >= 3'd5) |=> (res_o == '0));

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      // R7
      sel_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && op_i == 3'd4) |=>
            res_o[i*LANE_W +: LANE_W] == ($past(ge_o[i]) ? $past(opa_i[i*LANE_W +: LANE_W])
                                                          : $past(opb_i[i*LANE_W +: LANE_W])));
      // R6
      bsub_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_vld && op_i == 3'd3) |=>
            ge_o[i] == ($past(opa_i[i*LANE_W +: LANE_W]) >= $past(opb_i[i*LANE_W +: LANE_W])));
      if (i % 2 == 0) begin : g_pair
         // R3
         half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && op_i <= 3'd1) |=> ge_o[i] == ge_o[i+1]);
      end
   end
endmodule

bind simd_addsub_ge simd_ge_chk #(.LANE_W(LANE_W), .NUM_BYTES(NUM_BYTES)) chk_i (.*);

// File: tb/simd_addsub_ge_tb_top.sv
module simd_addsub_ge_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic [31:0] opa_i = '0, opb_i = '0;
   logic [31:0] res_o;
   logic        res_vld_o;
   logic [3:0]  ge_o;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   logic [31:0] m_res = '0;
   logic [3:0]  m_ge  = '0;
   logic        m_vld = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_addsub_ge dut_i (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check({tag, " result"}, res_o, m_res);
      check({tag, " ge"}, {28'd0, ge_o}, {28'd0, m_ge});
      check("R9 valid", {31'd0, res_vld_o}, {31'd0, m_vld});
   endtask

   task automatic model(input logic v, input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      int s;
      m_vld = v;
      if (!v) return;
      case (op)
         3'd0, 3'd1: begin
            logic [3:0] g;
            g = m_ge;
            for (int h = 0; h < 2; h++) begin
               int x, y;
               x = int'(a[h*16 +: 16]); y = int'(b[h*16 +: 16]);
               if (op == 3'd0) begin s = x + y; g[h*2] = (s > 65535); end
               else begin s = x - y; g[h*2] = (x >= y); end
               g[h*2+1] = g[h*2];
               m_res[h*16 +: 16] = s[15:0];
            end
            m_ge = g;
         end
         3'd2, 3'd3: begin
            for (int k = 0; k < 4; k++) begin
               int x, y;
               x = int'(a[k*8 +: 8]); y = int'(b[k*8 +: 8]);
               if (op == 3'd2) begin s = x + y; m_ge[k] = (s > 255); end
               else begin s = x - y; m_ge[k] = (x >= y); end
               m_res[k*8 +: 8] = s[7:0];
            end
         end
         3'd4: for (int k = 0; k < 4; k++)
                  m_res[k*8 +: 8] = m_ge[k] ? a[k*8 +: 8] : b[k*8 +: 8];
         default: m_res = '0;
      endcase
   endtask

   function automatic string tag_of(input logic v, input logic [2:0] op);
      if (!v) return "R8 idle";
      case (op)
         3'd0: return "R2,R3 hadd";
         3'd1: return "R4 hsub";
         3'd2: return "R5 badd";
         3'd3: return "R6 bsub";
         3'd4: return "R7,R8 select";
         default: return "R10,R8 reserved";
      endcase
   endfunction

   task automatic step(input logic v, input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      in_vld = v; op_i = op; opa_i = a; opb_i = b;
      @(posedge clk);
      model(v, op, a, b);
      #1;
      compare(tag_of(v, op));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_vld = 1'b0;
      #1;
      m_res = '0; m_ge = '0; m_vld = 1'b0;
      compare("R1 reset");
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      do_reset();
      // corner cases: all ones plus one, equal operands, zero minus one
      step(1, 3'd0, 32'hFFFF_FFFF, 32'h0001_0001);
      step(1, 3'd4, 32'hAABB_CCDD, 32'h1122_3344);
      step(1, 3'd2, 32'hFFFF_FFFF, 32'h0101_0101);
      step(1, 3'd1, 32'h0000_0000, 32'h0001_0001);
      step(1, 3'd4, 32'hAABB_CCDD, 32'h1122_3344);
      step(1, 3'd3, 32'h1234_5678, 32'h1234_5678);
      step(1, 3'd3, 32'h0000_0000, 32'h0101_0101);
      step(1, 3'd1, 32'h8000_0005, 32'h8000_0005);
      step(1, 3'd0, 32'h0000_FFFF, 32'h0000_0001);
      step(1, 3'd4, 32'hAABB_CCDD, 32'h1122_3344);
      step(1, 3'd3, 32'h10FF_0380, 32'h2001_0480);
      step(1, 3'd4, 32'hAABB_CCDD, 32'h1122_3344);
      step(1, 3'd5, 32'hDEAD_BEEF, 32'h1234_5678);
      step(0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      step(1, 3'd7, 32'h0, 32'h0);
      for (int n = 0; n < 600; n++) begin
         logic [2:0] op;
         op = 3'($urandom_range(0, 7));
         step(($urandom_range(0, 5) != 0), op, $urandom, $urandom);
         if (n == 300) do_reset();
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule